// File: doc/BRIEF.md
# Multi-Rate Clock-Enable Timing Controller

This block drives the enable strobes for a synchronous design that has more than one rate but only one clock. Every register downstream uses the single master clock. A slower rate domain is formed by qualifying its registers with a strobe from this controller, so no divided or gated clock is ever created.

An external global enable qualifies the whole controller. The base-rate strobe follows that enable directly. A 2-bit phase counter advances on each master-clock edge where the global enable is high, and it holds its value while the enable is low. The divided strobes are decoded from that counter:

- Two half-rate strobes, both at phase 1 of a two-cycle period. Phase 1 is also the last phase of that period, so the two strobes are identical.
- Two quarter-rate strobes, one at phase 1 and one at phase 3, the last phase, of a four-cycle period.

Phases are numbered from 0. A phase is the count of enabled cycles since reset, taken modulo the period. The period and phase of each strobe are set by constants in the package.

Top module: `clk_en_ctrl`

## Requirements
- R1: The phase advances only on master-clock edges where `en_i` is high. In any cycle where `en_i` is low, every divided strobe is low.
- R2: `base_en_o` equals `en_i` in every cycle, including during reset.
- R3: Let n be the number of cycles since reset release in which `en_i` was high, not counting the current cycle. `half_last_en_o` is high exactly when `en_i` is high and n mod 2 = 1. This is the last phase of the two-cycle period.
- R4: `half_p1_en_o` is high exactly when `en_i` is high and n mod 2 = 1. This is phase 1 of the two-cycle period.
- R5: `qtr_p1_en_o` is high exactly when `en_i` is high and n mod 4 = 1.
- R6: `qtr_last_en_o` is high exactly when `en_i` is high and n mod 4 = 3. It is never high in the same cycle as `qtr_p1_en_o`.
- R7: No divided strobe is high for two consecutive master-clock cycles.
- R8: While `rst_ni` is low, the phase is 0 and all divided strobes are low. The first enabled cycle after release is phase 0, so no divided strobe fires in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Global clock enable |
| base_en_o | output | 1 | Base-rate strobe |
| half_last_en_o | output | 1 | Half-rate strobe, last phase |
| half_p1_en_o | output | 1 | Half-rate strobe, phase 1 |
| qtr_p1_en_o | output | 1 | Quarter-rate strobe, phase 1 |
| qtr_last_en_o | output | 1 | Quarter-rate strobe, phase 3 |

## Verification
Some properties are checked by assertions on every cycle:

- The counter holds while the enable is low.
- The counter steps by exactly one while the enable is high.
- A strobe never appears without the enable.
- No strobe lasts two cycles.
- The two quarter-rate strobes never coincide.

The absolute phase of each strobe relative to reset, and its period across random gaps in the enable, can only be shown by the bench. The bench keeps its own count of enabled cycles. It compares each output against that count under a randomly toggled enable, long enabled runs and a reset asserted mid-run.

// File: rtl/clk_en_pkg.sv
package clk_en_pkg;
  localparam int unsigned NUM_STB = 4;
  // strobe order: half_last, half_p1, qtr_p1, qtr_last
  // DIV_LOG2: period = 2**DIV_LOG2 enabled cycles; PHASE: firing phase within it
  localparam int unsigned STB_DIV_LOG2 [NUM_STB] = '{1, 1, 2, 2};
  localparam int unsigned STB_PHASE    [NUM_STB] = '{1, 1, 1, 3};
endpackage

// File: rtl/clk_en_phase_cnt.sv
module clk_en_phase_cnt #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [CNT_W-1:0] phase_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_q + 1'b1;
  end

  assign phase_o = cnt_q;

  // R1
  phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(phase_o));
  // R1
  phase_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> phase_o == CNT_W'($past(phase_o) + 1'b1));
endmodule

// File: rtl/clk_en_decode.sv
module clk_en_decode #(
  parameter int unsigned CNT_W    = 2,
  parameter int unsigned DIV_LOG2 = 1,
  parameter int unsigned PHASE    = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] phase_i,
  output logic             stb_o
);
  if (DIV_LOG2 == 0) begin : g_base
    assign stb_o = en_i;
  end else begin : g_div
    assign stb_o = en_i && (phase_i[DIV_LOG2-1:0] == DIV_LOG2'(PHASE));

    // R7
    stb_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stb_o |=> !stb_o);
  end

  // R1
  stb_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |-> en_i);
endmodule

// File: rtl/clk_en_ctrl.sv
module clk_en_ctrl #(
  parameter int unsigned CNT_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic base_en_o,
  output logic half_last_en_o,
  output logic half_p1_en_o,
  output logic qtr_p1_en_o,
  output logic qtr_last_en_o
);
  import clk_en_pkg::*;

  logic [CNT_W-1:0]   phase;
  logic [NUM_STB-1:0] stb;

  clk_en_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .phase_o (phase)
  );

  for (genvar i = 0; i < NUM_STB; i++) begin : g_stb
    clk_en_decode #(
      .CNT_W    (CNT_W),
      .DIV_LOG2 (STB_DIV_LOG2[i]),
      .PHASE    (STB_PHASE[i])
    ) u_dec (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_i),
      .phase_i (phase),
      .stb_o   (stb[i])
    );
  end

  assign base_en_o      = en_i;
  assign half_last_en_o = stb[0];
  assign half_p1_en_o   = stb[1];
  assign qtr_p1_en_o    = stb[2];
  assign qtr_last_en_o  = stb[3];

  // R6
  qtr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(qtr_p1_en_o && qtr_last_en_o));
  // R5
  qtr_after_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qtr_p1_en_o |-> half_p1_en_o);
endmodule

// File: tb/clk_en_ctrl_tb.sv
module clk_en_ctrl_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b0;
  logic base_en, half_last, half_p1, qtr_p1, qtr_last;
  int checks = 0;
  int errors = 0;
  int unsigned ref_n = 0;
  logic [3:0] prev_stb = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  clk_en_ctrl u_dut (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .en_i           (en),
    .base_en_o      (base_en),
    .half_last_en_o (half_last),
    .half_p1_en_o   (half_p1),
    .qtr_p1_en_o    (qtr_p1),
    .qtr_last_en_o  (qtr_last)
  );

  // reference count of enabled cycles since reset release
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ref_n <= 0;
    else if (en) ref_n <= ref_n + 1;
  end

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) prev_stb <= '0;
    else prev_stb <= {half_last, half_p1, qtr_p1, qtr_last};
  end

  function automatic logic exp_stb(input logic e, input int unsigned n,
                                   input int unsigned per, input int unsigned ph);
    return e && ((n % per) == ph);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b (n=%0d en=%b)", req, act, exp, ref_n, en);
    end
  endtask

  // drive at negedge, check 1 ns later (before next posedge)
  task automatic step(input logic e);
    @(negedge clk);
    en = e;
    #1;
    chk("R2 base", base_en, en);
    if (!rst_ni) begin
      chk("R8 half_last", half_last, 1'b0);
      chk("R8 half_p1",   half_p1,   1'b0);
      chk("R8 qtr_p1",    qtr_p1,    1'b0);
      chk("R8 qtr_last",  qtr_last,  1'b0);
    end else begin
      chk("R3 half_last", half_last, exp_stb(en, ref_n, 2, 1));
      chk("R4 half_p1",   half_p1,   exp_stb(en, ref_n, 2, 1));
      chk("R5 qtr_p1",    qtr_p1,    exp_stb(en, ref_n, 4, 1));
      chk("R6 qtr_last",  qtr_last,  exp_stb(en, ref_n, 4, 3));
      if (!en) chk("R1 frozen", |{half_last, half_p1, qtr_p1, qtr_last}, 1'b0);
      chk("R7 no repeat", |(prev_stb & {half_last, half_p1, qtr_p1, qtr_last}), 1'b0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R8 reset with enable high
    for (int i = 0; i < 4; i++) step(1'b1);
    @(negedge clk);
    rst_ni = 1'b1;
    en = 1'b1;
    #1;
    // R8 first enabled cycle after release is phase 0
    chk("R8 first half", half_p1, 1'b0);
    chk("R8 first qtr",  qtr_p1 | qtr_last, 1'b0);
    // long run enabled
    for (int i = 0; i < 16; i++) step(1'b1);
    // gaps: R1 freeze
    for (int i = 0; i < 5; i++) step(1'b0);
    step(1'b1);
    for (int i = 0; i < 3; i++) step(1'b0);
    for (int i = 0; i < 8; i++) step(i[0]);
    // random stimulus
    for (int i = 0; i < 3000; i++) step(($urandom % 3) != 0);
    // mid-run reset
    @(negedge clk);
    rst_ni = 1'b0;
    for (int i = 0; i < 3; i++) step(1'b1);
    @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < 2000; i++) step(($urandom % 2) != 0);
    for (int i = 0; i < 12; i++) step(1'b1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule